// File: doc/BRIEF.md
# Read Burst Truncation Sequencer

This block sits in front of the command bus of one DDR SDRAM bank and turns read and write requests into timed commands. A read request carries a bank, a column, a burst length selector (four or eight beats), a CAS latency selector (two or two and a half clocks), an auto-precharge flag, the number of data pairs the requester wants to keep, and an end mode. The end mode says whether a shortened burst is cut with a burst-terminate command or with a precharge of the bank.

The sequencer issues READ in the cycle after acceptance. It counts clock cycles from that READ and places the end command exactly N cycles later, where N is the number of pairs kept. It drives a data-valid strobe over the read data window, and a phase flag marks the half-clock shift of the longer latency. It drops its ready output while the read window drains, and it keeps ready low for the bank's row precharge recovery after an explicit or automatic precharge. A WRITE therefore never reaches the bus before the read data and one turnaround cycle have passed. Requests that cannot be served are taken off the interface and flagged.

Top module: `rd_trunc_seq`

## Requirements
- R1: After reset, and in the cycle after a reset that cut into an active read, the command output is NOP, ready is high, and the strobe, both busy flags and the error flag are low.
- R2: The command field uses NOP=0, READ=1, WRITE=2, BST=3 and PRE=4. An accepted valid read puts READ on the bus in the cycle after acceptance, with the request's bank, column and auto-precharge flag. Every cycle that carries no command shows NOP.
- R3: For a read of N pairs, the data-valid strobe is high for exactly N consecutive cycles. It starts two cycles after READ. The late-phase flag is high with it when the 2.5 latency is selected and low for latency 2.
- R4: In terminate mode with N below half the burst length, BST is issued exactly N cycles after READ.
- R5: In terminate mode with N equal to half the burst length, no end command is issued.
- R6: In precharge mode, PRE is issued exactly N cycles after READ, for both shortened and full bursts.
- R7: A read request is rejected if N is zero, if N exceeds half the burst length, or if auto-precharge is combined with precharge mode or with a shortened burst. A rejected request is accepted off the interface. The error flag pulses for one cycle in the cycle after acceptance, no command is issued, and ready stays high.
- R8: Without precharge, ready stays low until the last kept pair plus, with latency 2.5, one further cycle. Ready returns in the turnaround cycle that follows. A pending WRITE therefore goes out no earlier than N+3 cycles after READ (N+4 with latency 2.5).
- R9: After PRE, no command is issued to the bank before TRP cycles have passed. Ready returns at max(N+2+late, N+TRP-1) cycles after READ.
- R10: A full-length read with auto-precharge releases ready in the same cycle as the same read ended by PRE in precharge mode.
- R11: A write request puts WRITE on the bus in the cycle after acceptance, leaves ready high and sets no busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | BANK_W | Bank address |
| req_col | input | COL_W | Column address |
| req_pairs | input | PAIR_W | Data pairs to keep |
| req_end_pre | input | 1 | End mode: 1 = precharge, 0 = burst terminate |
| req_bl8 | input | 1 | Burst length: 1 = eight beats, 0 = four |
| req_cl_late | input | 1 | CAS latency: 1 = 2.5, 0 = 2 |
| req_autopre | input | 1 | Read issued with auto-precharge |
| cmd_code | output | 3 | Command field |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_col | output | COL_W | Column of the issued command |
| cmd_ap | output | 1 | Auto-precharge flag carried with READ |
| rd_valid | output | 1 | A kept data pair is on the bus this cycle |
| rd_late | output | 1 | The current pair sits on the falling-edge phase |
| rd_busy | output | 1 | Read window active |
| pre_busy | output | 1 | Row precharge recovery running |
| req_err | output | 1 | Previous accepted request was rejected |

## Verification
The bench targets the off-by-one placements: BST or PRE one cycle early or late, and a one-pair read where the end command lands right after READ. A design with either error would return the wrong number of strobe cycles or place the end command on the wrong cycle. It also pins down when ready returns. If the turnaround cycle or the extra half-cycle of the 2.5 latency is missing, a held WRITE leaves a cycle early. If precharge recovery is missing, ready returns at the drain cycle instead of the recovery cycle. Rejection cases cover zero pairs, a pair count too large for the short burst, and both illegal auto-precharge combinations. A design that let any of these through would emit READ. The bench also checks that a full auto-precharge read and an explicitly precharged read release on the same cycle.

// File: rtl/rd_trunc_pkg.sv
package rd_trunc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_READ  = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_BST   = 3'd3,
        CMD_PRE   = 3'd4
    } cmd_e;

    // Width of the internal cycle counters and pair counts.
    localparam int unsigned CNT_W = 8;

    // CAS latency 2 expressed in half clocks.
    localparam int unsigned CL2_HALF_CLKS = 4;

    typedef struct packed {
        logic [CNT_W-1:0] pairs;    // pairs kept
        logic             full;     // pairs equal half the burst length
        logic             end_pre;  // end with precharge
        logic             ap;       // auto-precharge read
        logic             late;     // 2.5 latency selected
    } job_t;

    // Clock cycle after READ that carries the first pair.
    function automatic logic [CNT_W-1:0] first_pair_cycle(input logic late);
        logic [CNT_W-1:0] half_clks;
        half_clks = CNT_W'(CL2_HALF_CLKS) + CNT_W'(late);
        return half_clks >> 1;
    endfunction

    // Pairs contained in a full burst.
    function automatic logic [CNT_W-1:0] full_pairs(input logic bl8,
                                                    input int unsigned max_pairs);
        return bl8 ? CNT_W'(max_pairs) : CNT_W'(max_pairs / 2);
    endfunction

endpackage

// File: rtl/rd_trunc_admit.sv
module rd_trunc_admit
    import rd_trunc_pkg::*;
#(
    parameter int unsigned MAX_PAIRS = 4,
    parameter int unsigned PAIR_W    = 3
) (
    input  logic [PAIR_W-1:0] pairs,
    input  logic              bl8,
    input  logic              end_pre,
    input  logic              late,
    input  logic              ap,
    output logic              ok,
    output job_t              job
);

    logic [CNT_W-1:0] n;
    logic [CNT_W-1:0] full_n;
    logic             range_ok;
    logic             is_full;
    logic             ap_ok;

    always_comb begin
        n        = CNT_W'(pairs);
        full_n   = full_pairs(bl8, MAX_PAIRS);
        range_ok = (n != '0) && (n <= full_n);
        is_full  = (n == full_n);
        // auto-precharge only on an untruncated burst in terminate mode
        ap_ok    = !ap || (is_full && !end_pre);
        ok       = range_ok && ap_ok;
        job.pairs   = n;
        job.full    = is_full;
        job.end_pre = end_pre;
        job.ap      = ap;
        job.late    = late;
    end

endmodule

// File: rtl/rd_trunc_window.sv
module rd_trunc_window
    import rd_trunc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  job_t job_in,
    output job_t job,
    output logic active,
    output logic end_fire,
    output logic data_on
);

    logic [CNT_W-1:0] age;
    logic [CNT_W-1:0] first_c;
    logic [CNT_W-1:0] last_c;
    logic [CNT_W-1:0] drain_c;
    logic             drain_last;

    always_comb begin
        first_c    = first_pair_cycle(job.late);
        last_c     = first_c + job.pairs - CNT_W'(1);
        drain_c    = last_c + CNT_W'(job.late);
        drain_last = active && (age == drain_c);
        // end command goes out N cycles after READ; register stage adds one
        end_fire   = active && (age == job.pairs - CNT_W'(1));
        data_on    = active && (age >= first_c) && (age <= last_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            age    <= '0;
            job    <= '0;
        end else if (start) begin
            active <= 1'b1;
            age    <= '0;
            job    <= job_in;
        end else if (active) begin
            if (drain_last) begin
                active <= 1'b0;
            end else begin
                age <= age + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/rd_trunc_recovery.sv
module rd_trunc_recovery #(
    parameter int unsigned TRP   = 5,
    parameter int unsigned PRE_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    logic [PRE_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (start) begin
            left <= PRE_W'(TRP - 1);
        end else if (left != '0) begin
            left <= left - PRE_W'(1);
        end
    end

    assign busy = (left != '0);

endmodule

// File: rtl/rd_trunc_seq.sv
module rd_trunc_seq
    import rd_trunc_pkg::*;
#(
    parameter  int unsigned BANK_W    = 2,
    parameter  int unsigned COL_W     = 10,
    parameter  int unsigned MAX_PAIRS = 4,
    parameter  int unsigned TRP       = 5,
    localparam int unsigned PAIR_W    = $clog2(MAX_PAIRS + 1),
    localparam int unsigned PRE_W     = $clog2(TRP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [PAIR_W-1:0] req_pairs,
    input  logic              req_end_pre,
    input  logic              req_bl8,
    input  logic              req_cl_late,
    input  logic              req_autopre,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              rd_valid,
    output logic              rd_late,
    output logic              rd_busy,
    output logic              pre_busy,
    output logic              req_err
);

    logic        accept;
    logic        adm_ok;
    job_t        adm_job;
    job_t        win_job;
    logic        win_active;
    logic        win_end;
    logic        win_data;
    logic        rd_start;
    logic        prech_start;
    cmd_e        cmd_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic        ap_q;
    logic        err_q;

    rd_trunc_admit #(
        .MAX_PAIRS (MAX_PAIRS),
        .PAIR_W    (PAIR_W)
    ) i_admit (
        .pairs   (req_pairs),
        .bl8     (req_bl8),
        .end_pre (req_end_pre),
        .late    (req_cl_late),
        .ap      (req_autopre),
        .ok      (adm_ok),
        .job     (adm_job)
    );

    rd_trunc_window i_window (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_start),
        .job_in   (adm_job),
        .job      (win_job),
        .active   (win_active),
        .end_fire (win_end),
        .data_on  (win_data)
    );

    rd_trunc_recovery #(
        .TRP   (TRP),
        .PRE_W (PRE_W)
    ) i_recovery (
        .clk   (clk),
        .rst   (rst),
        .start (prech_start),
        .busy  (pre_busy)
    );

    assign req_ready   = !win_active && !pre_busy;
    assign accept      = req_valid && req_ready;
    assign rd_start    = accept && !req_write && adm_ok;
    // explicit or automatic precharge both begin at the end cycle
    assign prech_start = win_end && (win_job.end_pre || win_job.ap);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            bank_q <= '0;
            col_q  <= '0;
            ap_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            cmd_q <= CMD_NOP;
            ap_q  <= 1'b0;
            err_q <= 1'b0;
            if (accept) begin
                bank_q <= req_bank;
                col_q  <= req_col;
                if (req_write) begin
                    cmd_q <= CMD_WRITE;
                end else if (adm_ok) begin
                    cmd_q <= CMD_READ;
                    ap_q  <= req_autopre;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (win_end) begin
                if (win_job.end_pre) begin
                    cmd_q <= CMD_PRE;
                end else if (!win_job.full) begin
                    cmd_q <= CMD_BST;
                end
            end
        end
    end

    assign cmd_code = cmd_q;
    assign cmd_bank = bank_q;
    assign cmd_col  = col_q;
    assign cmd_ap   = ap_q;
    assign rd_valid = win_data;
    assign rd_late  = win_data && win_job.late;
    assign rd_busy  = win_active;
    assign req_err  = err_q;

endmodule

// File: rtl/rd_trunc_chk.sv
module rd_trunc_chk
    import rd_trunc_pkg::*;
#(
    parameter int unsigned TRP = 5
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [2:0] cmd_code,
    input logic       rd_valid,
    input logic       rd_busy,
    input logic       pre_busy,
    input logic       req_err
);

    // R2
    cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_code <= 3'd4);

    // R2
    read_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_READ) |-> $past(req_valid && req_ready && !req_write));

    // R3
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_busy);

    // R6
    pre_starts_recovery_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_PRE) |-> (pre_busy || TRP == 1));

    // R7
    err_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (cmd_code == CMD_NOP && !rd_busy));

    // R8
    write_clear_of_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_WRITE) |-> (!rd_busy && !rd_valid));

    // R9
    no_cmd_in_recovery_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_READ || cmd_code == CMD_WRITE) |-> $past(!pre_busy));

endmodule

bind rd_trunc_seq rd_trunc_chk #(.TRP(TRP)) i_rd_trunc_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .cmd_code  (cmd_code),
    .rd_valid  (rd_valid),
    .rd_busy   (rd_busy),
    .pre_busy  (pre_busy),
    .req_err   (req_err)
);

// File: tb/test_rd_trunc_seq.sv
module test_rd_trunc_seq;

    localparam int unsigned TRP_C  = 5;
    localparam int unsigned MAXP   = 4;
    localparam int unsigned BANK_W = 2;
    localparam int unsigned COL_W  = 10;
    localparam int unsigned PAIR_W = 3;
    localparam int unsigned NVEC   = 14;

    typedef struct packed {
        logic       wr;
        logic [2:0] pairs;
        logic       end_pre;
        logic       bl8;
        logic       late;
        logic       ap;
        logic       exp_err;
        logic [2:0] exp_end;
        logic [3:0] exp_rel;
    } vec_t;

    // wr pairs pre bl8 late ap err end rel
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 4'd4},
        '{1'b0, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 4'd6},
        '{1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd6},
        '{1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 4'd5},
        '{1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4, 4'd8},
        '{1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 4'd8},
        '{1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 4'd5},
        '{1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 4'd0},
        '{1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 4'd0},
        '{1'b0, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 4'd0},
        '{1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 4'd0},
        '{1'b1, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0},
        '{1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 4'd5},
        '{1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 4'd3}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [PAIR_W-1:0] req_pairs = '0;
    logic              req_end_pre = 1'b0;
    logic              req_bl8 = 1'b0;
    logic              req_cl_late = 1'b0;
    logic              req_autopre = 1'b0;
    logic [2:0]        cmd_code;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0]  cmd_col;
    logic              cmd_ap;
    logic              rd_valid;
    logic              rd_late;
    logic              rd_busy;
    logic              pre_busy;
    logic              req_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rd_trunc_seq #(
        .BANK_W    (BANK_W),
        .COL_W     (COL_W),
        .MAX_PAIRS (MAXP),
        .TRP       (TRP_C)
    ) i_rd_trunc_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_bank    (req_bank),
        .req_col     (req_col),
        .req_pairs   (req_pairs),
        .req_end_pre (req_end_pre),
        .req_bl8     (req_bl8),
        .req_cl_late (req_cl_late),
        .req_autopre (req_autopre),
        .cmd_code    (cmd_code),
        .cmd_bank    (cmd_bank),
        .cmd_col     (cmd_col),
        .cmd_ap      (cmd_ap),
        .rd_valid    (rd_valid),
        .rd_late     (rd_late),
        .rd_busy     (rd_busy),
        .pre_busy    (pre_busy),
        .req_err     (req_err)
    );

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_req(input logic wr, input logic [2:0] pairs,
                           input logic end_pre, input logic bl8,
                           input logic late, input logic ap,
                           input logic [BANK_W-1:0] bank,
                           input logic [COL_W-1:0] col);
        req_write   = wr;
        req_pairs   = pairs;
        req_end_pre = end_pre;
        req_bl8     = bl8;
        req_cl_late = late;
        req_autopre = ap;
        req_bank    = bank;
        req_col     = col;
        req_valid   = 1'b1;
    endtask

    task automatic idle_checks(input string tag);
        check(tag, "cmd_code", int'(cmd_code), 0);
        check(tag, "req_ready", int'(req_ready), 1);
        check(tag, "rd_valid", int'(rd_valid), 0);
        check(tag, "rd_busy", int'(rd_busy), 0);
        check(tag, "pre_busy", int'(pre_busy), 0);
        check(tag, "req_err", int'(req_err), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        idle_checks("R1");

        for (int v = 0; v < NVEC; v++) begin
            vec_t  cv;
            int    n;
            bit    rd_ok;
            string end_tag;
            string rel_tag;
            cv    = VECS[v];
            n     = int'(cv.pairs);
            rd_ok = !cv.wr && !cv.exp_err;
            end_tag = (cv.exp_end == 3'd3) ? "R4" : (cv.exp_end == 3'd4) ? "R6" : "R5";
            rel_tag = cv.ap ? "R10" : (cv.end_pre ? "R9" : "R8");
            set_req(cv.wr, cv.pairs, cv.end_pre, cv.bl8, cv.late, cv.ap,
                    BANK_W'(v), COL_W'(v * 37 + 5));
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 12; k++) begin
                int exp_cmd;
                int exp_rdy;
                int exp_val;
                if (k == 0) exp_cmd = cv.wr ? 2 : (cv.exp_err ? 0 : 1);
                else if (rd_ok && k == n) exp_cmd = int'(cv.exp_end);
                else exp_cmd = 0;
                exp_rdy = rd_ok ? int'(k >= int'(cv.exp_rel)) : 1;
                exp_val = int'(rd_ok && k >= 2 && k <= n + 1);
                if (cv.wr) begin
                    // R11 write issue and no busy
                    check("R11", "cmd_code", int'(cmd_code), exp_cmd);
                    check("R11", "req_ready", int'(req_ready), 1);
                    check("R11", "rd_busy", int'(rd_busy), 0);
                end else if (cv.exp_err) begin
                    // R7 rejection
                    check("R7", "cmd_code", int'(cmd_code), 0);
                    check("R7", "req_err", int'(req_err), int'(k == 0));
                    check("R7", "req_ready", int'(req_ready), 1);
                    check("R7", "rd_busy", int'(rd_busy), 0);
                end else begin
                    if (k == n) check(end_tag, "end cmd", int'(cmd_code), exp_cmd);
                    else check("R2", "cmd_code", int'(cmd_code), exp_cmd);
                    check(rel_tag, "req_ready", int'(req_ready), exp_rdy);
                    check("R3", "rd_valid", int'(rd_valid), exp_val);
                    if (exp_val != 0)
                        check("R3", "rd_late", int'(rd_late), int'(cv.late));
                    if (k == 0) begin
                        check("R2", "cmd_bank", int'(cmd_bank), v % 4);
                        check("R2", "cmd_col", int'(cmd_col), v * 37 + 5);
                        check("R2", "cmd_ap", int'(cmd_ap), int'(cv.ap));
                    end
                end
                @(negedge clk);
            end
        end

        // R8 write held behind a two-pair terminated read
        set_req(1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 10'd100);
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            int exp_cmd;
            exp_cmd = (k == 0) ? 1 : (k == 2) ? 3 : (k == 5) ? 2 : 0;
            check("R8", "stall cmd", int'(cmd_code), exp_cmd);
            if (k < 4) check("R8", "stall ready", int'(req_ready), 0);
            if (k == 0) set_req(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 10'd200);
            if (k == 5) begin
                check("R8", "write col", int'(cmd_col), 200);
                req_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R1 reset in the middle of a precharge-mode read
        set_req(1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 10'd300);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", "busy before reset", int'(rd_busy), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle_checks("R1");
        @(negedge clk);
        idle_checks("R1");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule